// File: doc/BRIEF.md
# Display Column Dimming and Attribute Gate

This block decides, every scan clock, whether the column drivers of the digit being scanned may conduct. Three effects are folded into one registered enable. The first is a brightness level, made by pulse-width modulation. The second is a slow on/off rhythm applied to chosen digits (flash). The third is the same rhythm applied to the whole display (blink). Lowering brightness shortens the fraction of time the columns conduct. It never changes how hard they are driven.

The brightness code selects an on-count inside a repeating 15-slot frame. The eight levels are full, 80%, 53%, 40%, 27%, 20% and 13% duty, and blank. A single divider produces the slow rhythm. It runs visible for the first half of each 28,672-clock period and dark for the second half, which is about 2 Hz at the usual scan clock. Flash hides a digit in the dark half when that digit's bit is set in the flash mask. Blink hides every digit in the dark half and takes priority over flash. A synchronous reset restarts both counters. Displays that share a clock and a reset therefore stay in phase.

Top module: `dim_column_gate`

## Requirements
- R1: While `rst` is high, `col_en` is 0. The first clock edge after `rst` falls is cycle 0 of a new PWM frame and of a new visible half-period.
- R2: Brightness codes 0 to 7 give 15, 12, 8, 6, 4, 3, 2 and 0 enabled cycles in every 15-cycle frame. The enabled cycles are the first ones of the frame, counted from the reset release.
- R3: With brightness code 7, `col_en` is never 1.
- R4: The slow phase repeats every 28,672 clocks. It is visible for cycles 0 to 14,335 of each period, counted from the reset release, and dark for cycles 14,336 to 28,671.
- R5: When `flash_en` is 1 and bit `digit_sel` of `flash_mask` is 1 (bit i belongs to digit i), `col_en` is 0 in the dark half. Digits whose bit is 0 keep their brightness duty.
- R6: When `flash_en` is 0, `flash_mask` has no effect on `col_en`.
- R7: When `blink_en` is 1, `col_en` is 0 in the dark half for every digit, whatever `flash_en` and `flash_mask` hold.
- R8: `col_en` is a register. A change on any input shows at `col_en` after exactly one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst | input | 1 | Synchronous active-high reset; restarts both counters |
| bright | input | 3 | Brightness code, 0 = full, 7 = blank |
| flash_en | input | 1 | Enables per-digit flashing |
| blink_en | input | 1 | Enables whole-display blinking (overrides flash) |
| flash_mask | input | 8 | One flash bit per digit, bit i for digit i |
| digit_sel | input | 3 | Index of the digit currently being scanned |
| col_en | output | 1 | Registered column-drive enable |

## Verification
A table of attribute settings is applied twice: once inside the visible half, where only the duty count may vary, and once inside the dark half, where flash and blink must remove the enable. Comparing the on-count per frame separates the eight duty levels from one another. Comparing the two halves separates a masked digit from an unmasked one, flash enabled from flash disabled, and blink with and without flash. Directed cases check where the half-period boundaries fall, that a reset during the dark half immediately restores visibility and frame slot 0, and that the output lags its inputs by one cycle.

// File: rtl/dim_pkg.sv
package dim_pkg;

    localparam int FRAME_SLOTS = 15;
    localparam int SLOT_W      = $clog2(FRAME_SLOTS + 1);
    localparam int NUM_DIGITS  = 8;
    localparam int DIGIT_W     = $clog2(NUM_DIGITS);
    localparam int RHYTHM_DIV  = 28672;

    typedef enum logic [2:0] {
        LVL_FULL  = 3'd0,
        LVL_P80   = 3'd1,
        LVL_P53   = 3'd2,
        LVL_P40   = 3'd3,
        LVL_P27   = 3'd4,
        LVL_P20   = 3'd5,
        LVL_P13   = 3'd6,
        LVL_BLANK = 3'd7
    } level_e;

    typedef enum logic [1:0] {
        GATE_STEADY,
        GATE_FLASH,
        GATE_BLINK
    } gate_mode_e;

    typedef struct packed {
        level_e level;
        logic   flash_en;
        logic   blink_en;
    } attr_t;

    function automatic logic [SLOT_W-1:0] on_slots(input level_e lvl);
        logic [SLOT_W-1:0] n;
        unique case (lvl)
            LVL_FULL:  n = SLOT_W'(15);
            LVL_P80:   n = SLOT_W'(12);
            LVL_P53:   n = SLOT_W'(8);
            LVL_P40:   n = SLOT_W'(6);
            LVL_P27:   n = SLOT_W'(4);
            LVL_P20:   n = SLOT_W'(3);
            LVL_P13:   n = SLOT_W'(2);
            default:   n = '0;
        endcase
        return n;
    endfunction

    function automatic gate_mode_e pick_mode(input attr_t a);
        if (a.blink_en)      return GATE_BLINK;
        else if (a.flash_en) return GATE_FLASH;
        else                 return GATE_STEADY;
    endfunction

endpackage

// File: rtl/dim_slot_counter.sv
module dim_slot_counter
    import dim_pkg::*;
#(
    parameter int FRAME = FRAME_SLOTS
) (
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] slot
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(FRAME - 1);

    always_ff @(posedge clk) begin
        if (rst || slot == LAST) slot <= '0;
        else                     slot <= slot + 1'b1;
    end
endmodule

// File: rtl/dim_rhythm_phase.sv
module dim_rhythm_phase #(
    parameter int DIV = 28672
) (
    input  logic clk,
    input  logic rst,
    output logic visible
);
    localparam int CNT_W = $clog2(DIV);
    localparam int HALF  = DIV / 2;
    localparam logic [CNT_W-1:0] WRAP = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cnt == WRAP) cnt <= '0;
        else                    cnt <= cnt + 1'b1;
    end

    assign visible = (cnt < CNT_W'(HALF));
endmodule

// File: rtl/dim_gate_logic.sv
module dim_gate_logic
    import dim_pkg::*;
(
    input  attr_t             attr,
    input  logic              mask_bit,
    input  logic [SLOT_W-1:0] slot,
    input  logic              visible,
    output logic              en_next
);
    logic       duty_on;
    gate_mode_e mode;

    always_comb begin
        duty_on = (slot < on_slots(attr.level));
        mode    = pick_mode(attr);
        unique case (mode)
            GATE_BLINK:  en_next = duty_on && visible;
            GATE_FLASH:  en_next = duty_on && (visible || !mask_bit);
            default:     en_next = duty_on;
        endcase
    end
endmodule

// File: rtl/dim_column_gate.sv
module dim_column_gate
    import dim_pkg::*;
#(
    parameter int DIGITS = NUM_DIGITS,
    parameter int DIV    = RHYTHM_DIV,
    parameter int FRAME  = FRAME_SLOTS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [2:0]                bright,
    input  logic                      flash_en,
    input  logic                      blink_en,
    input  logic [DIGITS-1:0]         flash_mask,
    input  logic [$clog2(DIGITS)-1:0] digit_sel,
    output logic                      col_en
);
    logic [SLOT_W-1:0] slot;
    logic              phase_vis;
    logic              en_next;
    attr_t             attr;

    assign attr = '{level: level_e'(bright), flash_en: flash_en, blink_en: blink_en};

    dim_slot_counter #(.FRAME(FRAME)) u_slot (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    dim_rhythm_phase #(.DIV(DIV)) u_phase (
        .clk     (clk),
        .rst     (rst),
        .visible (phase_vis)
    );

    dim_gate_logic u_gate (
        .attr     (attr),
        .mask_bit (flash_mask[digit_sel]),
        .slot     (slot),
        .visible  (phase_vis),
        .en_next  (en_next)
    );

    always_ff @(posedge clk) begin
        if (rst) col_en <= 1'b0;
        else     col_en <= en_next;
    end
endmodule

// File: rtl/dim_column_gate_chk.sv
module dim_column_gate_chk #(
    parameter int DIGITS = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic [2:0]                bright,
    input logic                      flash_en,
    input logic                      blink_en,
    input logic [DIGITS-1:0]         flash_mask,
    input logic [$clog2(DIGITS)-1:0] digit_sel,
    input logic                      phase_vis,
    input logic                      col_en
);
    AST_RST_QUIET: assert property (@(posedge clk) rst |=> !col_en); // R1

    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
        (bright == 3'd7) |=> !col_en); // R3

    AST_FULL_STEADY: assert property (@(posedge clk) disable iff (rst)
        (bright == 3'd0 && !flash_en && !blink_en) |=> col_en); // R2

    AST_FLASH_HIDE: assert property (@(posedge clk) disable iff (rst)
        (flash_en && flash_mask[digit_sel] && !phase_vis) |=> !col_en); // R5

    AST_BLINK_HIDE: assert property (@(posedge clk) disable iff (rst)
        (blink_en && !phase_vis) |=> !col_en); // R7
endmodule

bind dim_column_gate dim_column_gate_chk #(.DIGITS(DIGITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bright     (bright),
    .flash_en   (flash_en),
    .blink_en   (blink_en),
    .flash_mask (flash_mask),
    .digit_sel  (digit_sel),
    .phase_vis  (phase_vis),
    .col_en     (col_en)
);

// File: tb/tb_dim_column_gate.sv
module tb_dim_column_gate;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_P     = 14336;
    localparam int FULL_P     = 28672;
    localparam int NV         = 10;

    // fields: bright[23:21] flash[20] blink[19] mask[18:11] digit[10:8] vis[7:4] dark[3:0]
    localparam logic [23:0] VEC [NV] = '{
        {3'd0, 1'b0, 1'b0, 8'h00, 3'd0, 4'd15, 4'd15},
        {3'd1, 1'b1, 1'b0, 8'h01, 3'd0, 4'd12, 4'd0 },
        {3'd2, 1'b1, 1'b0, 8'h01, 3'd1, 4'd8,  4'd8 },
        {3'd3, 1'b0, 1'b0, 8'hFF, 3'd5, 4'd6,  4'd6 },
        {3'd4, 1'b0, 1'b1, 8'h00, 3'd2, 4'd4,  4'd0 },
        {3'd5, 1'b1, 1'b1, 8'h80, 3'd7, 4'd3,  4'd0 },
        {3'd6, 1'b1, 1'b0, 8'h80, 3'd7, 4'd2,  4'd0 },
        {3'd7, 1'b0, 1'b0, 8'h00, 3'd0, 4'd0,  4'd0 },
        {3'd0, 1'b1, 1'b0, 8'h10, 3'd4, 4'd15, 4'd0 },
        {3'd0, 1'b1, 1'b1, 8'h00, 3'd3, 4'd15, 4'd0 }
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bright = '0;
    logic       flash_en = 1'b0;
    logic       blink_en = 1'b0;
    logic [7:0] flash_mask = '0;
    logic [2:0] digit_sel = '0;
    logic       col_en;

    int checks = 0;
    int errors = 0;
    int kc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) kc <= 0;
        else     kc <= kc + 1;
    end

    dim_column_gate dut (
        .clk        (clk),
        .rst        (rst),
        .bright     (bright),
        .flash_en   (flash_en),
        .blink_en   (blink_en),
        .flash_mask (flash_mask),
        .digit_sel  (digit_sel),
        .col_en     (col_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, kc);
        end
    endtask

    task automatic apply(input logic [23:0] v);
        bright     = v[23:21];
        flash_en   = v[20];
        blink_en   = v[19];
        flash_mask = v[18:11];
        digit_sel  = v[10:8];
    endtask

    task automatic frame_count(output int n);
        n = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (col_en) n++;
        end
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        // R1: reset state
        repeat (4) @(negedge clk);
        chk("R1 output low in reset", int'(col_en), 0);
        rst = 1'b0;

        // visible half: only duty matters (R2, R3)
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            frame_count(n);
            chk($sformatf("R2 visible vec%0d", i), n, int'(VEC[i][7:4]));
        end

        // dark half: flash and blink gating (R5, R6, R7, R3)
        while (kc != HALF_P + 4) @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            frame_count(n);
            chk($sformatf("R5 R6 R7 dark vec%0d", i), n, int'(VEC[i][3:0]));
        end

        // R1: reset in dark half restores slot 0 and the visible phase
        apply({3'd6, 1'b1, 1'b1, 8'h04, 3'd2, 8'h00});
        @(negedge clk);
        chk("R7 dark before reset", int'(col_en), 0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 restart slot0 visible", int'(col_en), 1);
        @(negedge clk);
        chk("R1 restart slot1", int'(col_en), 1);
        @(negedge clk);
        chk("R1 restart slot2 off", int'(col_en), 0);

        // R8: one cycle latency
        apply({3'd0, 1'b0, 1'b0, 8'h00, 3'd0, 8'h00});
        @(negedge clk);
        chk("R8 full after one edge", int'(col_en), 1);
        bright = 3'd7;
        @(negedge clk);
        chk("R8 blank after one edge", int'(col_en), 0);
        bright = 3'd0;
        @(negedge clk);
        chk("R8 full again", int'(col_en), 1);

        // R4: half-period boundaries with blink at full duty
        blink_en = 1'b1;
        while (kc != HALF_P) @(negedge clk);
        chk("R4 last visible cycle", int'(col_en), 1);
        @(negedge clk);
        chk("R4 first dark cycle", int'(col_en), 0);
        while (kc != FULL_P) @(negedge clk);
        chk("R4 last dark cycle", int'(col_en), 0);
        @(negedge clk);
        chk("R4 new period visible", int'(col_en), 1);

        finish_run();
    end
endmodule